// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Slice

This block is a purely combinational 4-bit datapath slice that works in one of two modes. In arithmetic mode it feeds two derived operands, X and Y, into a 4-bit ripple adder along with the carry input. X and Y are formed from A and B according to a 4-bit function code. In logic mode it applies one of sixteen bitwise two-input functions of A and B, and the carry input plays no part.

The slice exports group generate and group propagate terms taken from the adder operands. An external lookahead unit can use these to chain several slices. The slice also exports an all-ones flag on the result, which serves as an equality detector when the slice is set to subtract with the carry input low.

Top module: `alu4_slice`

## Requirements
- R1: With `mode`=1, `f` is a bitwise function of `a` and `b` chosen by `sel`: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 1111, 0100 ~(A&B), 0101 ~B, 0110 ~(A^B), 0111 A&~B, 1000 ~A|B, 1001 A^B, 1010 B, 1011 A|B, 1100 0000, 1101 A|~B, 1110 A&B, 1111 A.
- R2: With `mode`=1, `cout` is 0 and `f` does not depend on `cin`.
- R3: With `mode`=0, `f` = (X+Y+cin) mod 16, where (X,Y) per `sel` is: 0000 (A,1111), 0001 (A|B,1111), 0010 (A|~B,1111), 0011 (0000,1111), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,1111), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A|B,0000), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,0000).
- R4: With `mode`=0, `cout` is bit 4 of the 5-bit sum X+Y+cin.
- R5: `gen` is 1 exactly when X+Y (no carry input) is 16 or more. This holds in both modes.
- R6: `prop` is 1 exactly when X XOR Y equals 1111. This holds in both modes.
- R7: `aeqb` is 1 exactly when all four bits of `f` are 1.
- R8: Anchor codes in arithmetic mode: 0000 gives A−1+cin, 0110 gives A−B−1+cin, 1001 gives A+B+cin, 1100 gives A+A+cin, 1011 gives (A|B)+cin, 1111 gives A+cin, each taken mod 16. In arithmetic mode, `cout` == `gen` | (`prop` & `cin`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| cin | input | 1 | Carry input, used in arithmetic mode only |
| mode | input | 1 | 0 = arithmetic, 1 = bitwise logic |
| sel | input | 4 | Function code |
| f | output | 4 | Result |
| cout | output | 1 | Carry output, 0 in logic mode |
| gen | output | 1 | Group generate of adder operands |
| prop | output | 1 | Group propagate of adder operands |
| aeqb | output | 1 | High when `f` is 1111 |

## Verification
The anchor codes are applied first with hand-written closed formulas. This separates the subtract and decrement paths, where the carry input cancels a borrow, from the plain add and doubling paths. A sweep then covers every code in both modes, every A, every B and both carry values. In logic mode the sweep pairs each vector with its carry-flipped twin, so any leak of the carry into the result or the carry output shows up. The wrap-around corners tell group generate apart from group propagate: sums of exactly 15 raise only propagate, and sums of 16 and above raise generate.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned W = 4;
    localparam int unsigned SELW = 4;

    typedef logic [W-1:0] word_t;

    typedef struct packed {
        word_t x;
        word_t y;
    } addend_t;

    // Operand pair handed to the adder for each function code.
    function automatic addend_t pick_addends(input logic [SELW-1:0] code,
                                             input word_t a, input word_t b);
        addend_t r;
        word_t ones;
        ones = '1;
        unique case (code)
            4'b0000: r = '{a,        ones};
            4'b0001: r = '{a | b,    ones};
            4'b0010: r = '{a | ~b,   ones};
            4'b0011: r = '{'0,       ones};
            4'b0100: r = '{a,        a & ~b};
            4'b0101: r = '{a | b,    a & ~b};
            4'b0110: r = '{a,        ~b};
            4'b0111: r = '{a & ~b,   ones};
            4'b1000: r = '{a,        a & b};
            4'b1001: r = '{a,        b};
            4'b1010: r = '{a | ~b,   a & b};
            4'b1011: r = '{a | b,    '0};
            4'b1100: r = '{a,        a};
            4'b1101: r = '{a | b,    a};
            4'b1110: r = '{a | ~b,   a};
            default: r = '{a,        '0};
        endcase
        return r;
    endfunction

    // Bitwise function for logic mode.
    function automatic word_t bitwise_op(input logic [SELW-1:0] code,
                                         input word_t a, input word_t b);
        word_t r;
        unique case (code)
            4'b0000: r = ~a;
            4'b0001: r = ~(a | b);
            4'b0010: r = ~a & b;
            4'b0011: r = '1;
            4'b0100: r = ~(a & b);
            4'b0101: r = ~b;
            4'b0110: r = ~(a ^ b);
            4'b0111: r = a & ~b;
            4'b1000: r = ~a | b;
            4'b1001: r = a ^ b;
            4'b1010: r = b;
            4'b1011: r = a | b;
            4'b1100: r = '0;
            4'b1101: r = a | ~b;
            4'b1110: r = a & b;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu4_opsel.sv
module alu4_opsel
    import alu4_pkg::*;
(
    input  word_t             a,
    input  word_t             b,
    input  logic [SELW-1:0]   sel,
    output addend_t           addends,
    output word_t             logic_res
);

    always_comb begin
        addends   = pick_addends(sel, a, b);
        logic_res = bitwise_op(sel, a, b);
    end

endmodule

// File: rtl/alu4_adder.sv
module alu4_adder
    import alu4_pkg::*;
#(
    parameter int unsigned WIDTH = W
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             grp_gen,
    output logic             grp_prop
);

    logic [WIDTH-1:0] g_bit;
    logic [WIDTH-1:0] p_bit;
    logic [WIDTH:0]   chain;
    logic [WIDTH:0]   gen_acc;
    logic [WIDTH:0]   prop_acc;

    assign chain[0]    = cin;
    assign gen_acc[0]  = 1'b0;
    assign prop_acc[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bitcell
        assign g_bit[i]      = x[i] & y[i];
        assign p_bit[i]      = x[i] ^ y[i];
        assign sum[i]        = p_bit[i] ^ chain[i];
        assign chain[i+1]    = g_bit[i] | (p_bit[i] & chain[i]);
        assign gen_acc[i+1]  = g_bit[i] | (p_bit[i] & gen_acc[i]);
        assign prop_acc[i+1] = p_bit[i] & prop_acc[i];
    end

    assign cout     = chain[WIDTH];
    assign grp_gen  = gen_acc[WIDTH];
    assign grp_prop = prop_acc[WIDTH];

    // R8: ripple carry agrees with the lookahead form of the group terms
    always_comb begin
        a_r8_carry_matches_group: assert (cout == (grp_gen | (grp_prop & cin)));
        // R6: propagate excludes generate
        a_r6_prop_excl_gen: assert (!(grp_gen && grp_prop));
    end

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu4_pkg::*;
(
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       cin,
    input  logic       mode,
    input  logic [3:0] sel,
    output logic [3:0] f,
    output logic       cout,
    output logic       gen,
    output logic       prop,
    output logic       aeqb
);

    addend_t addends;
    word_t   logic_res;
    word_t   arith_res;
    logic    arith_carry;

    alu4_opsel u_opsel (
        .a         (a),
        .b         (b),
        .sel       (sel),
        .addends   (addends),
        .logic_res (logic_res)
    );

    alu4_adder #(.WIDTH(W)) u_adder (
        .x        (addends.x),
        .y        (addends.y),
        .cin      (cin),
        .sum      (arith_res),
        .cout     (arith_carry),
        .grp_gen  (gen),
        .grp_prop (prop)
    );

    assign f    = mode ? logic_res : arith_res;
    assign cout = mode ? 1'b0 : arith_carry;
    assign aeqb = &f;

    always_comb begin
        // R2: logic mode never raises the carry output
        if (mode) a_r2_no_carry_logic: assert (!cout);
        // R1: constant-zero code in logic mode
        if (mode && sel == 4'b1100) a_r1_zero_code: assert (f == 4'b0000);
        // R8: plain add code
        if (!mode && sel == 4'b1001)
            a_r8_add_code: assert ({cout, f} == ({1'b0, a} + {1'b0, b} + {4'b0, cin}));
        // R8: increment code carries only from 1111 with carry in
        if (!mode && sel == 4'b1111)
            a_r8_inc_code: assert (cout == (cin && a == 4'hF));
    end

endmodule

// File: tb/alu4_slice_bench.sv
module alu4_slice_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic [3:0] a, b, sel;
    logic       cin, mode;
    logic [3:0] f;
    logic       cout, gen, prop, aeqb;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu4_slice u_alu4_slice (
        .a(a), .b(b), .cin(cin), .mode(mode), .sel(sel),
        .f(f), .cout(cout), .gen(gen), .prop(prop), .aeqb(aeqb)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s sel=%b mode=%b a=%h b=%h cin=%b actual=%0d expected=%0d",
                     tag, what, sel, mode, a, b, cin, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic m, input logic [3:0] va,
                         input logic [3:0] vb, input logic c);
        @(negedge clk);
        sel = s; mode = m; a = va; b = vb; cin = c;
        #(CLK_PERIOD/4);
    endtask

    // Independent model of the operand pairs from the R3 table
    function automatic void model_xy(input logic [3:0] s, input logic [3:0] va,
                                     input logic [3:0] vb, output int x, output int y);
        int A, B, NB;
        A = va; B = vb; NB = 15 - vb;
        case (s)
            4'd0:  begin x = A;       y = 15;      end
            4'd1:  begin x = A | B;   y = 15;      end
            4'd2:  begin x = A | NB;  y = 15;      end
            4'd3:  begin x = 0;       y = 15;      end
            4'd4:  begin x = A;       y = A & NB;  end
            4'd5:  begin x = A | B;   y = A & NB;  end
            4'd6:  begin x = A;       y = NB;      end
            4'd7:  begin x = A & NB;  y = 15;      end
            4'd8:  begin x = A;       y = A & B;   end
            4'd9:  begin x = A;       y = B;       end
            4'd10: begin x = A | NB;  y = A & B;   end
            4'd11: begin x = A | B;   y = 0;       end
            4'd12: begin x = A;       y = A;       end
            4'd13: begin x = A | B;   y = A;       end
            4'd14: begin x = A | NB;  y = A;       end
            default: begin x = A;     y = 0;       end
        endcase
    endfunction

    function automatic int model_logic(input logic [3:0] s, input logic [3:0] va,
                                       input logic [3:0] vb);
        int A, B;
        A = va; B = vb;
        case (s)
            4'd0:  return 15 - A;
            4'd1:  return 15 - (A | B);
            4'd2:  return (15 - A) & B;
            4'd3:  return 15;
            4'd4:  return 15 - (A & B);
            4'd5:  return 15 - B;
            4'd6:  return 15 - (A ^ B);
            4'd7:  return A & (15 - B);
            4'd8:  return (15 - A) | B;
            4'd9:  return A ^ B;
            4'd10: return B;
            4'd11: return A | B;
            4'd12: return 0;
            4'd13: return A | (15 - B);
            4'd14: return A & B;
            default: return A;
        endcase
    endfunction

    // Output state before any stimulus settles to a known pattern
    task automatic t_idle_zero();
        apply(4'b1001, 1'b0, 4'h0, 4'h0, 1'b0);
        chk("R3", f, 0, "f idle add");
        chk("R4", cout, 0, "cout idle add");
        chk("R7", aeqb, 0, "aeqb idle");
    endtask

    // Anchor codes with closed formulas (R8)
    task automatic t_anchor_codes();
        for (int va = 0; va < 16; va++) begin
            for (int vb = 0; vb < 16; vb++) begin
                for (int c = 0; c < 2; c++) begin
                    apply(4'b0000, 1'b0, va[3:0], vb[3:0], c[0]);
                    chk("R8", f, (va - 1 + c) & 15, "dec");
                    apply(4'b0110, 1'b0, va[3:0], vb[3:0], c[0]);
                    chk("R8", f, (va - vb - 1 + c) & 15, "sub");
                    chk("R8", cout, int'(gen | (prop & cin)), "cout vs group");
                    apply(4'b1001, 1'b0, va[3:0], vb[3:0], c[0]);
                    chk("R8", f, (va + vb + c) & 15, "add");
                    apply(4'b1100, 1'b0, va[3:0], vb[3:0], c[0]);
                    chk("R8", f, (va + va + c) & 15, "double");
                    apply(4'b1011, 1'b0, va[3:0], vb[3:0], c[0]);
                    chk("R8", f, ((va | vb) + c) & 15, "or plus");
                    apply(4'b1111, 1'b0, va[3:0], vb[3:0], c[0]);
                    chk("R8", f, (va + c) & 15, "inc");
                end
            end
        end
    endtask

    // Group terms at the wrap corners (R5, R6)
    task automatic t_group_corners();
        apply(4'b1001, 1'b0, 4'h7, 4'h8, 1'b0);
        chk("R6", prop, 1, "prop at 15");
        chk("R5", gen, 0, "gen at 15");
        apply(4'b1001, 1'b0, 4'h7, 4'h8, 1'b1);
        chk("R4", cout, 1, "cout ripple through");
        chk("R7", aeqb, 0, "aeqb after wrap");
        apply(4'b1001, 1'b0, 4'h8, 4'h8, 1'b0);
        chk("R5", gen, 1, "gen at 16");
        chk("R6", prop, 0, "prop at 16");
        apply(4'b0110, 1'b0, 4'h5, 4'h5, 1'b0);
        chk("R7", aeqb, 1, "equal operands subtract");
    endtask

    // Every code, both modes, every operand and carry
    task automatic t_sweep();
        int x, y, s5, exp_f;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int va = 0; va < 16; va++) begin
                    for (int vb = 0; vb < 16; vb++) begin
                        for (int c = 0; c < 2; c++) begin
                            apply(s[3:0], m[0], va[3:0], vb[3:0], c[0]);
                            model_xy(s[3:0], va[3:0], vb[3:0], x, y);
                            if (m == 0) begin
                                s5 = x + y + c;
                                exp_f = s5 & 15;
                                chk("R3", f, exp_f, "arith f");
                                chk("R4", cout, (s5 >> 4) & 1, "arith cout");
                            end else begin
                                exp_f = model_logic(s[3:0], va[3:0], vb[3:0]);
                                chk("R1", f, exp_f, "logic f");
                                chk("R2", cout, 0, "logic cout");
                            end
                            chk("R5", gen, int'((x + y) >= 16), "gen");
                            chk("R6", prop, int'((x ^ y) == 15), "prop");
                            chk("R7", aeqb, int'(exp_f == 15), "aeqb");
                        end
                    end
                end
            end
        end
    endtask

    // Logic mode result unchanged when only cin flips (R2)
    task automatic t_logic_cin_ignored();
        int f0;
        for (int s = 0; s < 16; s++) begin
            apply(s[3:0], 1'b1, 4'hA, 4'h6, 1'b0);
            f0 = f;
            apply(s[3:0], 1'b1, 4'hA, 4'h6, 1'b1);
            chk("R2", f, f0, "cin flip logic f");
            chk("R2", cout, 0, "cin flip logic cout");
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles >= WATCHDOG_CYCLES) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d expected=done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; sel = '0; cin = 1'b0; mode = 1'b0;
        t_idle_zero();
        t_anchor_codes();
        t_group_corners();
        t_logic_cin_ignored();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule